// File: doc/BRIEF.md
# Interleaved ADC Sample Assembler

This block rebuilds full-width converter samples from a narrow input bus that carries half of every sample per system clock cycle. It runs from one system clock, generates a converter clock at half that rate through a register, and reads the bus on consecutive cycles. One cycle carries the even-numbered bits of the sample and the next carries the odd-numbered bits. The two halves are not contiguous bytes. Each half is therefore spread onto alternate positions of a full-width register, and the two registers are merged with a bitwise OR, so no multiplexer is needed.

The bus passes through one register stage before any capture logic. The phase of the converter clock, as seen at the output pin, tells the source which half to present. A parameter swaps which phase carries the even half. Each assembled sample is announced by a one-cycle valid strobe, at most once every two cycles. Reset is asynchronous and active low.

Top module: `ilv_adc_capture`

## Requirements
- R1: After reset is released, `conv_clk_o` changes value on every rising edge of `clk`, so it runs at half the system clock rate. It is 1 throughout the first cycle after release.
- R2: While `rst_n` is low, `conv_clk_o` is 1, `sample_o` is all zeros and `sample_vld_o` is 0, with no clock edge needed.
- R3: With `PHASE_INV` = 0, the bus value in a cycle during which `conv_clk_o` is 0 is the even half: bus bit i becomes sample bit 2i. The bus value in a cycle during which `conv_clk_o` is 1 is the odd half: bus bit i becomes sample bit 2i+1.
- R4: Each assembled sample equals the bitwise OR of the spread even half and the spread odd half, and it reproduces the original word exactly.
- R5: `sample_vld_o` is high in the third cycle after the cycle that carried the odd half. In that cycle `conv_clk_o` equals the value of `PHASE_INV`.
- R6: `sample_vld_o` never stays high for two consecutive cycles.
- R7: After reset, no sample is produced until an even half and then an odd half have been captured. An odd half that arrives before any even half is discarded.
- R8: With `PHASE_INV` = 1, the roles swap: the half presented while `conv_clk_o` is 1 is the even half, and the half presented while it is 0 is the odd half.
- R9: `sample_o` keeps its value in every cycle where `sample_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data_i | input | HALF_W | Half-sample bus from the converter |
| conv_clk_o | output | 1 | Registered converter clock at half the system rate |
| sample_o | output | 2*HALF_W | Last assembled sample |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The hardest situation to reach is the start-up alignment right after reset. Here the first half on the bus may be an odd half with no partner, and it must be dropped rather than paired with stale or reset contents. The bench releases reset a moment after a rising edge, so the first bus value falls in the odd phase for one instance and in the even phase for the other. It then re-enters reset after a full run, holds a constant byte on the bus, and confirms that the first strobe appears only in the sixth cycle. Every 16-bit word is streamed through the non-inverted instance in a scrambled order, which covers all bit patterns of both halves.

// File: rtl/ilv_cap_pkg.sv
package ilv_cap_pkg;
  typedef enum logic {
    HALF_EVEN = 1'b0,
    HALF_ODD  = 1'b1
  } half_sel_e;

  function automatic half_sel_e half_for_phase(input logic phase, input logic invert);
    return (phase ^ invert) ? HALF_ODD : HALF_EVEN;
  endfunction
endpackage

// File: rtl/ilv_clk_div.sv
module ilv_clk_div (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o,
  output logic conv_clk_o
);
  logic phase_q, phase_d;
  logic pin_q, pin_d;

  always_comb begin
    phase_d = ~phase_q;
    pin_d   = phase_q;
  end

  // pin register reset high: pin level in cycle c matches phase in cycle c+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pin_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      pin_q   <= pin_d;
    end
  end

  assign phase_o    = phase_q;
  assign conv_clk_o = pin_q;
endmodule

// File: rtl/ilv_in_pipe.sv
module ilv_in_pipe #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] bus_i,
  output logic [HALF_W-1:0] bus_q_o,
  output logic              live_o
);
  logic [HALF_W-1:0] bus_q;
  logic              live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= '0;
      live_q <= 1'b0;
    end else begin
      bus_q  <= bus_i;
      live_q <= 1'b1;
    end
  end

  assign bus_q_o = bus_q;
  assign live_o  = live_q;
endmodule

// File: rtl/ilv_half_scatter.sv
module ilv_half_scatter #(
  parameter int HALF_W  = 8,
  parameter int ODD_POS = 0
) (
  input  logic [HALF_W-1:0]   half_i,
  output logic [2*HALF_W-1:0] spread_o
);
  localparam int OFS = (ODD_POS != 0) ? 1 : 0;

  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign spread_o[2*i + OFS]     = half_i[i];
    assign spread_o[2*i + 1 - OFS] = 1'b0;
  end
endmodule

// File: rtl/ilv_merge.sv
module ilv_merge
  import ilv_cap_pkg::*;
#(
  parameter int HALF_W    = 8,
  parameter int PHASE_INV = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                phase_i,
  input  logic                live_i,
  input  logic [2*HALF_W-1:0] even_spread_i,
  input  logic [2*HALF_W-1:0] odd_spread_i,
  output logic [2*HALF_W-1:0] sample_o,
  output logic                sample_vld_o
);
  localparam int   SAMPLE_W = 2 * HALF_W;
  localparam logic INV      = (PHASE_INV != 0);

  half_sel_e           cur_half;
  logic                even_en, odd_en, sample_en;
  logic [SAMPLE_W-1:0] even_q, odd_q, sample_q, sample_d;
  logic                have_even_q, have_even_d;
  logic                pair_q, pair_d;
  logic                vld_q, vld_d;

  always_comb begin
    cur_half    = half_for_phase(phase_i, INV);
    even_en     = live_i && (cur_half == HALF_EVEN);
    odd_en      = live_i && (cur_half == HALF_ODD);
    have_even_d = have_even_q | even_en;
    pair_d      = odd_en & have_even_q;
    sample_en   = pair_q;
    sample_d    = even_q | odd_q;
    vld_d       = pair_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q      <= '0;
      odd_q       <= '0;
      have_even_q <= 1'b0;
      pair_q      <= 1'b0;
      sample_q    <= '0;
      vld_q       <= 1'b0;
    end else begin
      if (even_en)   even_q   <= even_spread_i;
      if (odd_en)    odd_q    <= odd_spread_i;
      if (sample_en) sample_q <= sample_d;
      have_even_q <= have_even_d;
      pair_q      <= pair_d;
      vld_q       <= vld_d;
    end
  end

  assign sample_o     = sample_q;
  assign sample_vld_o = vld_q;
endmodule

// File: rtl/ilv_adc_capture.sv
module ilv_adc_capture #(
  parameter int HALF_W    = 8,
  parameter int PHASE_INV = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   adc_data_i,
  output logic                conv_clk_o,
  output logic [2*HALF_W-1:0] sample_o,
  output logic                sample_vld_o
);
  localparam int SAMPLE_W = 2 * HALF_W;

  logic                phase;
  logic                live;
  logic [HALF_W-1:0]   bus_q;
  logic [SAMPLE_W-1:0] even_spread, odd_spread;

  ilv_clk_div u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_o    (phase),
    .conv_clk_o (conv_clk_o)
  );

  ilv_in_pipe #(.HALF_W(HALF_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_i   (adc_data_i),
    .bus_q_o (bus_q),
    .live_o  (live)
  );

  ilv_half_scatter #(.HALF_W(HALF_W), .ODD_POS(0)) u_even (
    .half_i   (bus_q),
    .spread_o (even_spread)
  );

  ilv_half_scatter #(.HALF_W(HALF_W), .ODD_POS(1)) u_odd (
    .half_i   (bus_q),
    .spread_o (odd_spread)
  );

  ilv_merge #(.HALF_W(HALF_W), .PHASE_INV(PHASE_INV)) u_merge (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_i       (phase),
    .live_i        (live),
    .even_spread_i (even_spread),
    .odd_spread_i  (odd_spread),
    .sample_o      (sample_o),
    .sample_vld_o  (sample_vld_o)
  );
endmodule

// File: rtl/ilv_capture_chk.sv
module ilv_capture_chk #(
  parameter int PHASE_INV = 0,
  parameter int SAMPLE_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_clk_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                sample_vld_o
);
  localparam logic INV = (PHASE_INV != 0);

  logic       seen_q;
  logic [2:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end
  end

  // R1
  conv_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (conv_clk_o != $past(conv_clk_o)));

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |=> !sample_vld_o);

  // R9
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld_o |-> $stable(sample_o));

  // R5
  vld_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> (conv_clk_o == INV));

  // R7
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q < 3'd4) |-> !sample_vld_o);
endmodule

bind ilv_adc_capture ilv_capture_chk #(
  .PHASE_INV (PHASE_INV),
  .SAMPLE_W  (SAMPLE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_clk_o   (conv_clk_o),
  .sample_o     (sample_o),
  .sample_vld_o (sample_vld_o)
);

// File: tb/tb_ilv_lane.sv
module tb_ilv_lane #(
  parameter int INV    = 0,
  parameter int NWORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        conv,
  input  logic [15:0] sample,
  input  logic        vld,
  output logic [7:0]  data_o,
  output logic        done,
  output int          checks,
  output int          errors
);
  logic [15:0] q_w[$];
  int          q_t[$];

  function automatic logic [15:0] pattern(input int idx);
    return 16'((idx * 40503 + 4660) & 16'hFFFF);
  endfunction

  initial begin
    int          t;
    int          idx;
    logic        pending;
    logic        prev;
    logic [15:0] word;
    logic [15:0] ew;
    int          et;
    data_o = 8'h00; done = 1'b0; checks = 0; errors = 0;
    t = 0; idx = 0; pending = 1'b0; prev = 1'b1; word = '0;
    wait (run && rst_n);
    while (!done) begin
      @(negedge clk);
      t++;
      // R1: pin is 1 in the first cycle and toggles afterwards
      checks++;
      if ((t == 1 && conv !== 1'b1) || (t > 1 && conv === prev)) begin
        errors++;
        $display("FAIL R1 inv=%0d t=%0d conv actual=%b expected=%b", INV, t, conv, (t == 1) ? 1'b1 : ~prev);
      end
      prev = conv;
      if (vld) begin
        checks++;
        if (q_w.size() == 0) begin
          errors++;
          $display("FAIL R7 inv=%0d t=%0d unexpected valid actual=1 expected=0", INV, t);
        end else begin
          ew = q_w.pop_front(); et = q_t.pop_front();
          // R4 / R3 / R8: reassembled word
          if (sample !== ew) begin
            errors++;
            $display("FAIL R4 inv=%0d sample actual=%h expected=%h", INV, sample, ew);
          end
          checks++;
          // R5: latency of three cycles after the odd half
          if (t != et) begin
            errors++;
            $display("FAIL R5 inv=%0d valid cycle actual=%0d expected=%0d", INV, t, et);
          end
        end
      end else if (q_t.size() != 0 && q_t[0] <= t) begin
        checks++; errors++;
        $display("FAIL R5 inv=%0d missing valid at cycle actual=none expected=%0d", INV, q_t[0]);
        void'(q_w.pop_front()); void'(q_t.pop_front());
      end
      // drive next half; R3 (INV=0) / R8 (INV=1) phase rule
      if (conv == INV[0]) begin
        if (idx < NWORDS) begin
          word = pattern(idx);
          for (int i = 0; i < 8; i++) data_o[i] = word[2*i];
          pending = 1'b1;
        end else begin
          data_o = 8'h00; pending = 1'b0;
        end
      end else if (pending) begin
        for (int i = 0; i < 8; i++) data_o[i] = word[2*i+1];
        q_w.push_back(word); q_t.push_back(t + 3);
        idx++; pending = 1'b0;
      end else begin
        data_o = 8'hA5;
      end
      if (idx >= NWORDS && q_w.size() == 0) done = 1'b1;
    end
  end
endmodule

// File: tb/tb_ilv_adc_capture.sv
module tb_ilv_adc_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [7:0]  tb_data;
  logic [7:0]  lane0_data, lane1_data;
  logic        conv0, conv1, vld0, vld1;
  logic [15:0] smp0, smp1;
  logic        done0, done1;
  int          chk0, err0, chk1, err1;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  ilv_adc_capture #(.HALF_W(8), .PHASE_INV(0)) dut (
    .clk (clk), .rst_n (rst_n), .adc_data_i (run ? lane0_data : tb_data),
    .conv_clk_o (conv0), .sample_o (smp0), .sample_vld_o (vld0)
  );

  ilv_adc_capture #(.HALF_W(8), .PHASE_INV(1)) dut_inv (
    .clk (clk), .rst_n (rst_n), .adc_data_i (run ? lane1_data : tb_data),
    .conv_clk_o (conv1), .sample_o (smp1), .sample_vld_o (vld1)
  );

  tb_ilv_lane #(.INV(0), .NWORDS(65536)) lane0 (
    .clk (clk), .rst_n (rst_n), .run (run), .conv (conv0), .sample (smp0), .vld (vld0),
    .data_o (lane0_data), .done (done0), .checks (chk0), .errors (err0)
  );

  tb_ilv_lane #(.INV(1), .NWORDS(512)) lane1 (
    .clk (clk), .rst_n (rst_n), .run (run), .conv (conv1), .sample (smp1), .vld (vld1),
    .data_o (lane1_data), .done (done1), .checks (chk1), .errors (err1)
  );

  function automatic logic [15:0] weave(input logic [7:0] ev, input logic [7:0] od);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = ev[i];
      r[2*i+1] = od[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks + chk0 + chk1, errors + err0 + err1);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; tb_data = 8'h00;
    repeat (3) @(negedge clk);
    // R2: reset values on both instances
    check("R2 conv", {31'd0, conv0}, 32'd1);
    check("R2 sample", {16'd0, smp0}, 32'd0);
    check("R2 vld", {31'd0, vld0}, 32'd0);
    check("R2 inv conv", {31'd0, conv1}, 32'd1);
    check("R2 inv vld", {31'd0, vld1}, 32'd0);
    @(posedge clk); #1;
    run = 1'b1; rst_n = 1'b1;
    wait (done0 && done1);
    @(negedge clk);
    run = 1'b0; tb_data = 8'h3C;
    #2 rst_n = 1'b0;
    #1;
    // R2: reset takes effect without a clock edge
    check("R2 async conv", {31'd0, conv0}, 32'd1);
    check("R2 async sample", {16'd0, smp0}, 32'd0);
    check("R2 async vld", {31'd0, vld0}, 32'd0);
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R7: cycle 1 carries an unpaired odd half; first strobe in cycle 6
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      check($sformatf("R7 no valid cycle %0d", c), {31'd0, vld0}, 32'd0);
      check($sformatf("R9 hold cycle %0d", c), {16'd0, smp0}, 32'd0);
    end
    @(negedge clk);
    check("R7 first valid", {31'd0, vld0}, 32'd1);
    check("R4 constant bus word", {16'd0, smp0}, {16'd0, weave(8'h3C, 8'h3C)});
    @(negedge clk);
    check("R6 strobe drops", {31'd0, vld0}, 32'd0);
    check("R9 held after strobe", {16'd0, smp0}, {16'd0, weave(8'h3C, 8'h3C)});
    finish_run();
  end
endmodule